// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block is a write-only serial configuration port for a dual-loop frequency synthesizer. A host drives three lines: a serial clock, a serial data line, and an active-low frame enable. While the enable is low, each rising edge of the serial clock moves one bit into a 21-bit shift register, most significant bit first. When the enable returns high, the lowest four bits of the shift register are taken as an address and the upper seventeen bits as the payload. The payload is written into one of five configuration registers: loop A divide ratio, loop B divide ratio, reference divide ratio with its half-rate select, a control word, and a test word. The register contents drive parallel outputs.

The three serial lines are asynchronous to the system clock. They are resynchronised, and their edges are detected in the system clock domain. The divider logic raises `ratio_sample` while it reads its ratio registers. A commit that arrives during that window is held back until the window closes, so a divider never reads a ratio that is partly updated.

Top module: `serial_cfg_loader`

## Requirements
- R1: A frame is sent MSB first. The last 21 bits are split into a 17-bit payload (upper bits) and a 4-bit address (the final four bits). Address 4'b0001 writes the payload into `loop_a_div`.
- R2: Serial clock rising edges seen while `ser_en_n` is high shift nothing. A later commit with no new bits therefore rewrites the previous frame unchanged.
- R3: There is no check on the number of bits. When more than 21 bits arrive in one frame, only the last 21 are kept and the extra leading bits are discarded.
- R4: Address 4'b0011 writes `loop_b_div`. Address 4'b1111 writes `test_word`. Address 4'b0010 writes the reference register: payload bit 16 goes to `ref_half` and payload bits 11:0 go to `ref_div`.
- R5: A frame that carries any other address (0, 5 to 14) changes no output.
- R6: A write takes effect only after `ser_en_n` rises. Shifting bits in, with enable held low, changes no output. Each commit writes at most one register.
- R7: While `ratio_sample` is high, no output changes. A commit that arrives in that window is applied once `ratio_sample` falls.
- R8: Reset (`rst_n` low) clears every register to zero, so both loops come up with software power enables at 0 (off).
- R9: The level of `ser_clk` when `ser_en_n` rises does not affect the commit.
- R10: The control word (address 4'b0100) maps payload bits as follows: bit 0 `pwr_on_a`, bit 1 `pwr_on_b`, bit 2 `xtal_keep`, bits 6:3 `port_hiz[3:0]`, bit 7 `pump_en`, bits 9:8 `lock_sel`, bits 11:10 `pump_gain`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en_n | input | 1 | Frame enable, active low; rising edge commits |
| ratio_sample | input | 1 | High while dividers read their ratios; holds off commits |
| loop_a_div | output | 17 | Loop A main divide ratio |
| loop_b_div | output | 17 | Loop B main divide ratio |
| ref_div | output | 12 | Reference divide ratio |
| ref_half | output | 1 | Loop B reference at half rate |
| pwr_on_a | output | 1 | Loop A software power enable |
| pwr_on_b | output | 1 | Loop B software power enable |
| xtal_keep | output | 1 | Keep crystal buffer on when both loops are off |
| port_hiz | output | 4 | Port output bits, 1 = high impedance |
| pump_en | output | 1 | Pump supply enable |
| lock_sel | output | 2 | Out-of-lock output selection |
| pump_gain | output | 2 | Charge-pump gain selects for loops A and B |
| test_word | output | 17 | Test register, zero in normal use |

## Verification
The hardest states to reach are the ones where the serial lines do something the host would normally never do. One is clock pulses sent while enable is idle; the other is a commit that lands inside a ratio-sampling window. For the first, the bench sends junk pulses with enable high and then opens an empty frame. A shifted-in junk bit would move the old frame's address to 4'b1111, and the test register would expose it. For the second, the bench holds `ratio_sample` high across a full commit. It confirms the outputs are frozen, then releases `ratio_sample` and confirms the deferred write appears.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int unsigned DATA_W   = 17;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned FRAME_W  = DATA_W + ADDR_W;
  localparam int unsigned REF_W    = 12;
  localparam int unsigned NUM_REGS = 5;

  // slot indices into the register bank
  localparam int unsigned SLOT_LOOPA = 0;
  localparam int unsigned SLOT_REF   = 1;
  localparam int unsigned SLOT_LOOPB = 2;
  localparam int unsigned SLOT_CTRL  = 3;
  localparam int unsigned SLOT_TEST  = 4;

  // control word field positions
  localparam int unsigned CB_PWR_A = 0;
  localparam int unsigned CB_PWR_B = 1;
  localparam int unsigned CB_XTAL  = 2;
  localparam int unsigned CB_PORT  = 3;
  localparam int unsigned CB_PUMP  = 7;
  localparam int unsigned CB_LOCK  = 8;
  localparam int unsigned CB_GAIN  = 10;
  localparam int unsigned REF_HALF_BIT = DATA_W - 1;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [FRAME_W-1:0] frame_t;

  function automatic addr_t slot_addr(int unsigned slot);
    case (slot)
      SLOT_LOOPA: return addr_t'(1);
      SLOT_REF:   return addr_t'(2);
      SLOT_LOOPB: return addr_t'(3);
      SLOT_CTRL:  return addr_t'(4);
      SLOT_TEST:  return addr_t'(15);
      default:    return addr_t'(0);
    endcase
  endfunction

  function automatic addr_t frame_addr(frame_t f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic word_t frame_data(frame_t f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  function automatic frame_t shift_in(frame_t f, logic b);
    return {f[FRAME_W-2:0], b};
  endfunction
endpackage

// File: rtl/spl_sync.sv
module spl_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spl_front.sv
module spl_front
  import spl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_s,
  input  logic   sdat_s,
  input  logic   sen_s,
  input  logic   hold_i,
  output frame_t shreg_o,
  output frame_t frame_o,
  output logic   load_o
);
  logic   sclk_d, sen_d, pend_q;
  logic   sclk_rise, sen_rise, shift_en;
  frame_t sh_q, fr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sen_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      sen_d  <= sen_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sen_rise  = sen_s & ~sen_d;
  assign shift_en  = sclk_rise & ~sen_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= shift_in(sh_q, sdat_s);
  end

  // snapshot at commit, so a deferred load is not disturbed by a new frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q   <= '0;
      pend_q <= 1'b0;
    end else if (sen_rise) begin
      fr_q   <= sh_q;
      pend_q <= 1'b1;
    end else if (pend_q && !hold_i) begin
      pend_q <= 1'b0;
    end
  end

  assign load_o  = pend_q & ~hold_i;
  assign shreg_o = sh_q;
  assign frame_o = fr_q;
endmodule

// File: rtl/spl_bank.sv
module spl_bank
  import spl_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_i,
  input  frame_t                            frame_i,
  output logic [NUM_REGS-1:0]               wr_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o
);
  addr_t dec_addr;
  word_t dec_data;

  assign dec_addr = frame_addr(frame_i);
  assign dec_data = frame_data(frame_i);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign wr_o[g] = load_i && (dec_addr == slot_addr(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       regs_o[g] <= '0;
      else if (wr_o[g]) regs_o[g] <= dec_data;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import spl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                ser_data,
  input  logic                ser_en_n,
  input  logic                ratio_sample,
  output logic [DATA_W-1:0]   loop_a_div,
  output logic [DATA_W-1:0]   loop_b_div,
  output logic [REF_W-1:0]    ref_div,
  output logic                ref_half,
  output logic                pwr_on_a,
  output logic                pwr_on_b,
  output logic                xtal_keep,
  output logic [3:0]          port_hiz,
  output logic                pump_en,
  output logic [1:0]          lock_sel,
  output logic [1:0]          pump_gain,
  output logic [DATA_W-1:0]   test_word
);
  logic [2:0] line_s;
  logic       sclk_s, sdat_s, sen_s;
  frame_t     sh_q, frame_q;
  logic       load_pulse;
  logic [NUM_REGS-1:0]             wr_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  word_t      ref_w, ctl_w;
  logic       unused_bits;

  spl_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_en_n, ser_data, ser_clk}),
    .q(line_s)
  );
  assign sclk_s = line_s[0];
  assign sdat_s = line_s[1];
  assign sen_s  = line_s[2];

  spl_front u_front (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sdat_s(sdat_s), .sen_s(sen_s),
    .hold_i(ratio_sample),
    .shreg_o(sh_q), .frame_o(frame_q), .load_o(load_pulse)
  );

  spl_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_pulse), .frame_i(frame_q),
    .wr_o(wr_vec), .regs_o(regs_q)
  );

  assign ref_w = regs_q[SLOT_REF];
  assign ctl_w = regs_q[SLOT_CTRL];

  assign loop_a_div = regs_q[SLOT_LOOPA];
  assign loop_b_div = regs_q[SLOT_LOOPB];
  assign test_word  = regs_q[SLOT_TEST];
  assign ref_div    = ref_w[REF_W-1:0];
  assign ref_half   = ref_w[REF_HALF_BIT];
  assign pwr_on_a   = ctl_w[CB_PWR_A];
  assign pwr_on_b   = ctl_w[CB_PWR_B];
  assign xtal_keep  = ctl_w[CB_XTAL];
  assign port_hiz   = ctl_w[CB_PORT +: 4];
  assign pump_en    = ctl_w[CB_PUMP];
  assign lock_sel   = ctl_w[CB_LOCK +: 2];
  assign pump_gain  = ctl_w[CB_GAIN +: 2];

  assign unused_bits = ^{ref_w[REF_HALF_BIT-1:REF_W], ctl_w[DATA_W-1:CB_GAIN+2]};
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk
  import spl_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            sen_s,
  input logic                            ratio_sample,
  input logic                            load_pulse,
  input logic [NUM_REGS-1:0]             wr_vec,
  input frame_t                          sh_q,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
  // R2
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_s |=> $stable(sh_q));

  // R7
  sample_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_sample |=> $stable(regs_q));

  // R6
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  // R5
  quiet_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(regs_q));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sen_s(sen_s), .ratio_sample(ratio_sample),
  .load_pulse(load_pulse), .wr_vec(wr_vec), .sh_q(sh_q), .regs_q(regs_q)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en_n = 1'b1, ratio_sample = 1'b0;
  logic [16:0] loop_a_div, loop_b_div, test_word;
  logic [11:0] ref_div;
  logic ref_half, pwr_on_a, pwr_on_b, xtal_keep, pump_en;
  logic [3:0] port_hiz;
  logic [1:0] lock_sel, pump_gain;

  int n_cmp = 0;
  int n_bad = 0;
  logic [16:0] exp_a, exp_b, exp_ref, exp_ctl, exp_test;

  always #10 clk = ~clk;

  serial_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en_n(ser_en_n), .ratio_sample(ratio_sample),
    .loop_a_div(loop_a_div), .loop_b_div(loop_b_div), .ref_div(ref_div),
    .ref_half(ref_half), .pwr_on_a(pwr_on_a), .pwr_on_b(pwr_on_b),
    .xtal_keep(xtal_keep), .port_hiz(port_hiz), .pump_en(pump_en),
    .lock_sel(lock_sel), .pump_gain(pump_gain), .test_word(test_word)
  );

  task automatic model_clear();
    exp_a = '0; exp_b = '0; exp_ref = '0; exp_ctl = '0; exp_test = '0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [16:0] d);
    case (a)
      4'd1:  exp_a = d;
      4'd2:  exp_ref = d;
      4'd3:  exp_b = d;
      4'd4:  exp_ctl = d;
      4'd15: exp_test = d;
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    logic [75:0] obs, expv;
    obs  = {loop_a_div, loop_b_div, ref_half, ref_div, pwr_on_a, pwr_on_b,
            xtal_keep, port_hiz, pump_en, lock_sel, pump_gain, test_word};
    expv = {exp_a, exp_b, exp_ref[16], exp_ref[11:0], exp_ctl[0], exp_ctl[1],
            exp_ctl[2], exp_ctl[6:3], exp_ctl[7], exp_ctl[9:8], exp_ctl[11:10], exp_test};
    n_cmp++;
    if (obs !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, obs, expv);
    end
  endtask

  task automatic pulse_bit(input logic b);
    ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse_bit(v[i]);
  endtask

  task automatic open_frame();
    ser_en_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (4) @(negedge clk);
    ser_en_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic write_frame(input logic [3:0] a, input logic [16:0] d);
    open_frame();
    send_bits({43'd0, d, a}, 21);
    close_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [16:0] d;
    model_clear();
    repeat (5) @(negedge clk);
    // R8: reset state, everything zero, loops powered off
    check_all("R8 reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R8 after release");

    // sweep every address with an arithmetic payload
    for (int a = 0; a < 16; a++) begin
      d = 17'((a * 24307 + 5171) % 131072);
      write_frame(4'(a), d);
      model_write(4'(a), d);
      case (a)
        1:       check_all("R1 loop A write");
        2:       check_all("R4 reference write");
        3:       check_all("R4 loop B write");
        4:       check_all("R10 control write");
        15:      check_all("R4 test write");
        default: check_all("R5 unused address ignored");
      endcase
    end

    // R10: walking one through each control field bit
    for (int b = 0; b < 12; b++) begin
      d = 17'(1) << b;
      write_frame(4'd4, d);
      model_write(4'd4, d);
      check_all("R10 control bit map");
    end
    write_frame(4'd15, '0);
    model_write(4'd15, '0);
    check_all("R4 test cleared");

    // R3: nine leading junk bits are dropped
    open_frame();
    send_bits(64'h1FF, 9);
    send_bits({43'd0, 17'h1B3C5, 4'd3}, 21);
    close_frame();
    model_write(4'd3, 17'h1B3C5);
    check_all("R3 excess leading bits");

    // R2: clock pulses with enable high are not shifted
    write_frame(4'd1, 17'h0F0F1);
    model_write(4'd1, 17'h0F0F1);
    for (int k = 0; k < 5; k++) pulse_bit(1'b1);
    open_frame();
    close_frame();
    check_all("R2 idle clocks ignored");

    // R6: no effect before enable rises
    open_frame();
    send_bits({43'd0, 17'h12345, 4'd1}, 21);
    repeat (12) @(negedge clk);
    check_all("R6 no write before commit");
    ser_en_n = 1'b1;
    repeat (12) @(negedge clk);
    model_write(4'd1, 17'h12345);
    check_all("R6 write at commit");

    // R9: commit while serial clock is high
    open_frame();
    send_bits({43'd0, 17'h0ABCD, 4'd3} >> 1, 20);
    ser_data = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_en_n = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (10) @(negedge clk);
    model_write(4'd3, 17'h0ABCD);
    check_all("R9 commit with clock high");

    // R7: commit deferred while dividers sample
    ratio_sample = 1'b1;
    write_frame(4'd2, 17'h10FED);
    repeat (10) @(negedge clk);
    check_all("R7 held during sample");
    ratio_sample = 1'b0;
    repeat (4) @(negedge clk);
    model_write(4'd2, 17'h10FED);
    check_all("R7 applied after sample");

    // R8: reset again mid-run
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_clear();
    check_all("R8 reset clears");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule